// File: doc/BRIEF.md
# Dataflow Multiply Node with Completion Handshake

This block wraps a small multi-cycle unsigned multiplier so that it behaves as one node of a dataflow graph. An upstream controller raises `up_valid` when every operand feeding the node is valid. The node then latches both operands and forms their product by adding the first operand to an accumulator once per cycle, as many times as the second operand says. When the product is ready, the node raises `done`, which tells downstream nodes that they may run.

`done` is sticky. It stays high until a one-cycle `done_clr` pulse arrives from an iterating loop. It also falls when a fresh rising edge of `up_valid` starts a new run. This second path lets the node keep working in a single-cycle loop, where no clear pulse is ever sent. The product output is a register of its own, so it stays put while downstream logic consumes it.

Top module: `flow_mul_node`

## Requirements
- R1: While `rst` is high, `done` is 0 and `product` is 0.
- R2: A run starts only on a rising edge of `up_valid`, meaning it is 1 at a clock edge after being 0 at the previous edge (the first edge after reset counts as a rise). It starts only when the node is idle or done, and `op_a`/`op_b` are captured at that edge.
- R3: On completion `product` equals `op_a * op_b` as captured, unsigned and of full width (`A_W + B_W` bits).
- R4: `done` first reads 1 after the clock edge that lies `b + 1` edges after the capturing edge, where `b` is the captured `op_b`. For `b = 0` that is the edge right after capture. `done` is 0 in every cycle before that.
- R5: Changes on `op_a`, `op_b` and rising edges of `up_valid` during a run have no effect on that run's product or timing.
- R6: Once `done` is 1, it stays 1 while `up_valid` stays high and no `done_clr` arrives, and no second run starts.
- R7: If `done_clr` is 1 at a clock edge, `done` is 0 after that edge. This includes the completion edge, where the clear wins, `done` never rises, and `product` is still updated.
- R8: `product` changes only at a completion edge and holds its value while `done` is 1 and after a clear.
- R9: With no clear, after `up_valid` falls and rises again, the node starts a new run and `done` drops at the capturing edge. `done` stays 1 while `up_valid` is low.
- R10: After a clear, with `up_valid` still high, no run starts and `done` stays 0 until `up_valid` falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| up_valid | input | 1 | Upstream operands valid; a rising edge starts a run |
| done_clr | input | 1 | Loop clear pulse; forces `done` low at the next edge |
| op_a | input | A_W | Multiplicand |
| op_b | input | B_W | Multiplier, also the add count |
| product | output | A_W+B_W | Registered product of the last completed run |
| done | output | 1 | Sticky completion flag |

## Verification
Runs are driven with random operands, including `op_b` at zero and at its maximum, and with three ways of ending a run. In the first, a clear arrives after `done` has been seen. In the second, the clear lands on the completion edge. In the third, no clear ever arrives and `up_valid` is simply toggled, as in a single-cycle loop. These endings separate a correct priority between clear, completion and restart from designs that only handle one loop style. During each run the operands are scrambled and `up_valid` is toggled at random, which exposes a design that fails to latch its operands or that restarts while busy. The cycle of the `done` rise is checked against `b + 1` exactly, which catches off-by-one errors in the add counter.

// File: rtl/fmn_pkg.sv
package fmn_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } node_st_e;

endpackage

// File: rtl/fmn_ctrl.sv
module fmn_ctrl
    import fmn_pkg::*;
#(
    parameter int B_W = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           up_valid,
    input  logic           done_clr,
    input  logic [B_W-1:0] op_b,
    output logic           load,
    output logic           step,
    output logic           finish,
    output logic           done
);

    typedef struct packed {
        node_st_e       st;
        logic           up_prev;
        logic [B_W-1:0] cnt;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  rise;

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.up_prev = up_valid;
        load          = 1'b0;
        step          = 1'b0;
        finish        = 1'b0;
        rise          = up_valid & ~ctl_q.up_prev;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (rise) begin
                    ctl_d.st  = ST_BUSY;
                    ctl_d.cnt = op_b;
                    load      = 1'b1;
                end
            end
            ST_BUSY: begin
                if (ctl_q.cnt == '0) begin
                    finish   = 1'b1;
                    ctl_d.st = done_clr ? ST_IDLE : ST_DONE;
                end else begin
                    step      = 1'b1;
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_DONE: begin
                if (rise) begin
                    ctl_d.st  = ST_BUSY;
                    ctl_d.cnt = op_b;
                    load      = 1'b1;
                end else if (done_clr) begin
                    ctl_d.st = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.st      <= ST_IDLE;
            ctl_q.up_prev <= 1'b0;
            ctl_q.cnt     <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign done = (ctl_q.st == ST_DONE);

    // R2: a rise seen outside a run moves the node into BUSY
    p_start_on_rise_r2: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.st != ST_BUSY && up_valid && !ctl_q.up_prev) |=> (ctl_q.st == ST_BUSY));

    // R5: a run is never restarted while busy
    p_busy_no_restart_r5: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.st == ST_BUSY && ctl_q.cnt != '0) |=> (ctl_q.st == ST_BUSY && ctl_q.cnt == $past(ctl_q.cnt) - 1'b1));

    // R7: a clear on the completion edge sends the node to IDLE
    p_finish_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (finish && done_clr) |=> (ctl_q.st == ST_IDLE));

endmodule

// File: rtl/fmn_accum.sv
module fmn_accum #(
    parameter int A_W = 8,
    parameter int B_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic                 step,
    input  logic                 finish,
    input  logic [A_W-1:0]       op_a,
    output logic [A_W+B_W-1:0]   product
);

    localparam int R_W = A_W + B_W;

    typedef struct packed {
        logic [A_W-1:0] a;
        logic [R_W-1:0] acc;
        logic [R_W-1:0] res;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (load) begin
            acc_d.a   = op_a;
            acc_d.acc = '0;
        end else if (step) begin
            acc_d.acc = acc_q.acc + R_W'(acc_q.a);
        end
        if (finish) begin
            acc_d.res = acc_q.acc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign product = acc_q.res;

    // R8: the product register moves only on a completion edge
    p_product_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !finish |=> $stable(product));

    // R5: the latched multiplicand is untouched outside a load
    p_operand_kept_r5: assert property (@(posedge clk) disable iff (rst)
        !load |=> (acc_q.a == $past(acc_q.a)));

endmodule

// File: rtl/flow_mul_node.sv
module flow_mul_node #(
    parameter int A_W = 8,
    parameter int B_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 up_valid,
    input  logic                 done_clr,
    input  logic [A_W-1:0]       op_a,
    input  logic [B_W-1:0]       op_b,
    output logic [A_W+B_W-1:0]   product,
    output logic                 done
);

    logic load, step, finish;

    fmn_ctrl #(.B_W(B_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .up_valid (up_valid),
        .done_clr (done_clr),
        .op_b     (op_b),
        .load     (load),
        .step     (step),
        .finish   (finish),
        .done     (done)
    );

    fmn_accum #(.A_W(A_W), .B_W(B_W)) u_accum (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .step    (step),
        .finish  (finish),
        .op_a    (op_a),
        .product (product)
    );

    // R7: a clear forces done low after the next edge
    p_clear_drops_r7: assert property (@(posedge clk) disable iff (rst)
        done_clr |=> !done);

    // R6: done is sticky without a clear or a fresh rise
    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (done && !done_clr && !(up_valid && !$past(up_valid))) |=> done);

    // R8: product is stable while done stays high
    p_hold_while_done_r8: assert property (@(posedge clk) disable iff (rst)
        (done && $past(done)) |-> $stable(product));

    // R1: reset clears the outputs
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (!done && product == '0));

endmodule

// File: tb/test_flow_mul_node.sv
`timescale 1ns/1ps
module test_flow_mul_node;

    localparam int A_W = 8;
    localparam int B_W = 4;
    localparam int R_W = A_W + B_W;

    logic           clk = 1'b0;
    logic           rst;
    logic           up_valid;
    logic           done_clr;
    logic [A_W-1:0] op_a;
    logic [B_W-1:0] op_b;
    logic [R_W-1:0] product;
    logic           done;

    int vectors = 0;
    int fails   = 0;

    always #2.5 clk = ~clk;

    flow_mul_node #(.A_W(A_W), .B_W(B_W)) i_flow_mul_node (
        .clk      (clk),
        .rst      (rst),
        .up_valid (up_valid),
        .done_clr (done_clr),
        .op_a     (op_a),
        .op_b     (op_b),
        .product  (product),
        .done     (done)
    );

    function automatic int exp_prod(int a, int b);
        return a * b;
    endfunction

    task automatic chk(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // mode 0: clear after done; mode 1: clear on completion edge; mode 2: no clear
    task automatic run_op(int a, int b, int mode);
        int p;
        p = exp_prod(a, b);
        @(negedge clk);
        up_valid = 1'b1;
        op_a     = A_W'(a);
        op_b     = B_W'(b);
        for (int j = 0; j <= b + 1; j++) begin
            @(negedge clk);
            if (j == 0) chk("R4/R9 done low after capture", int'(done), 0);
            else chk("R4 done timing", int'(done), (j == b + 1 && mode != 1) ? 1 : 0);
            if (j == b + 1) chk("R3/R5 product", int'(product), p);
            op_a     = A_W'($urandom);
            op_b     = B_W'($urandom);
            up_valid = (j < b) ? 1'($urandom % 2) : 1'b1;
            done_clr = (mode == 1 && j == b) ? 1'b1 : 1'b0;
        end
        done_clr = 1'b0;
        if (mode == 0) begin
            repeat (2) begin
                @(negedge clk);
                chk("R6 sticky", int'(done), 1);
                chk("R8 hold", int'(product), p);
            end
            done_clr = 1'b1;
            @(negedge clk);
            done_clr = 1'b0;
            chk("R7 clear", int'(done), 0);
            chk("R8 after clear", int'(product), p);
            repeat (2) begin
                @(negedge clk);
                chk("R10 no restart", int'(done), 0);
            end
        end else if (mode == 1) begin
            repeat (2) begin
                @(negedge clk);
                chk("R7/R10 clear wins", int'(done), 0);
                chk("R7 product still written", int'(product), p);
            end
        end else begin
            repeat (2) begin
                @(negedge clk);
                chk("R6 sticky", int'(done), 1);
            end
        end
        up_valid = 1'b0;
        @(negedge clk);
        if (mode == 2) chk("R9 stays high while low", int'(done), 1);
        chk("R8 hold", int'(product), p);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        rst      = 1'b1;
        up_valid = 1'b0;
        done_clr = 1'b0;
        op_a     = '0;
        op_b     = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset done", int'(done), 0);
        chk("R1 reset product", int'(product), 0);
        rst = 1'b0;

        run_op(37, 0, 0);
        run_op(255, 15, 2);
        run_op(200, 9, 2);
        run_op(0, 7, 1);
        run_op(91, 0, 1);
        run_op(255, 15, 0);
        for (int k = 0; k < 40; k++) begin
            run_op(int'($urandom % 256), int'($urandom % 16), int'($urandom % 3));
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule